// File: doc/BRIEF.md
# Windowed watchdog reset timer

This block guards a system against software that has stopped running or is running out of order. Once software turns it on, a 7-bit counter counts down at a rate set by a prescaler. Software must reload the counter before it drops below 0x40, and it may not reload too soon. A reload made while the count is still above a programmable window value is treated as a fault, just like a missed deadline. Either fault produces a one-cycle reset request, which an external system reset controller acts on.

Software reaches the block through three 32-bit registers. The control register holds the counter and a sticky enable bit, and a write to it is the refresh. The configuration register holds the window value and the prescaler select. The status register holds a flag that marks the counter reaching its last live value. The register port has a valid/ready handshake. Ready is always high, so there is no back-pressure, and a transfer completes in every cycle in which valid is high. A write is taken at the clock edge, and read data is returned in the same cycle as the request.

After a reset request the block is halted. The counter stops, register writes have no effect, and no further requests are made until the synchronous reset input is applied.

Top module: `win_watchdog`

## Requirements
- R1: After reset: enable is 0, the counter is 0x7F, the window is 0x7F, the prescaler select is 0, the status flag is 0 and `rst_req` is 0.
- R2: The enable bit is control bit 7. Writing 1 sets it. A later control write with bit 7 at 0 does not clear it; only the `rst` input does.
- R3: While the block is disabled the counter does not move. A control write while disabled loads bits 6:0 into the counter, and no reset request follows.
- R4: While enabled, the counter decrements once every `BASE_DIV << psel` cycles, where psel is configuration bits 8:7. Every control write restarts the prescaler, so the first decrement comes exactly one period after the write edge.
- R5: Without a refresh, `rst_req` rises on the tick that takes the counter from 0x40 to 0x3F. For a loaded value V that is `max(V-0x3F,1) * period` cycles after the write edge. A loaded value at or below 0x40 expires on the first tick.
- R6: A control write while enabled, with the current count at or below the window (configuration bits 6:0), reloads the counter and causes no reset request.
- R7: A control write while enabled, with the current count strictly above the window, raises `rst_req` in the cycle right after the write edge.
- R8: `rst_req` is high for exactly one cycle. After it, the counter is frozen, register writes are ignored and no further request comes until `rst`.
- R9: Status bit 0 is set on the tick that brings the counter to 0x40. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R10: Register offsets: control 0x0 ({enable, count[6:0]}), configuration 0x4 ({psel[8:7], window[6:0]}), status 0x8 (flag in bit 0). Any other offset reads as 0, and `bus_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous system reset, active high |
| bus_valid | input | 1 | Register transfer request |
| bus_ready | output | 1 | Transfer accepted, always high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request, otherwise 0 |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The expiry path is driven with random loaded values and random prescaler selects, which separates per-tick timing errors from errors in the count range. It is also driven with loads at and below 0x40, which separate the floor comparison from the rollover. The refresh path uses random windows and random refresh times: the count at the moment of the write, whether above, equal to or below the window, decides between a reload and an immediate request. Directed sequences cover the sticky enable, the frozen state after a trip, and the set and clear rules of the status flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 7;
  localparam int PSEL_W = 2;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam int EN_BIT   = CNT_W;
  localparam int PSEL_LSB = CNT_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h8);

  localparam logic [CNT_W-1:0] LIVE_FLOOR = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] CNT_INIT   = '1;
  localparam logic [CNT_W-1:0] WIN_INIT   = '1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_DIV = 4,
  parameter int PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << PSEL_W) - 1);
  localparam int PW      = $clog2(MAX_DIV) + 1;

  logic [PW-1:0] div_cnt;
  logic [PW-1:0] reload;

  always_comb reload = PW'((BASE_DIV << psel) - 1);

  assign tick = run && (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) div_cnt <= reload;
    else                                div_cnt <= div_cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             hit_floor
);
  logic step;

  assign step      = run && tick && !load;
  assign expire    = step && (count <= LIVE_FLOOR);
  assign hit_floor = step && (count == LIVE_FLOOR + CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       count <= CNT_INIT;
    else if (load) count <= load_val;
    else if (step) count <= count - 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              halted,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag_set,
  output logic              enable,
  output logic [CNT_W-1:0]  window,
  output logic [PSEL_W-1:0] psel,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              early,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ok, ctrl_wr, cfg_wr, stat_wr, rd_req;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:PSEL_LSB+PSEL_W];

  assign wr_ok   = bus_valid && bus_write && !halted;
  assign ctrl_wr = wr_ok && (bus_addr == OFS_CTRL);
  assign cfg_wr  = wr_ok && (bus_addr == OFS_CFG);
  assign stat_wr = wr_ok && (bus_addr == OFS_STAT);
  assign rd_req  = bus_valid && !bus_write;

  assign load     = ctrl_wr;
  assign load_val = bus_wdata[CNT_W-1:0];
  assign early    = ctrl_wr && enable && (count > window);

  always_ff @(posedge clk) begin
    if (rst)                              enable <= 1'b0;
    else if (ctrl_wr && bus_wdata[EN_BIT]) enable <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      window <= WIN_INIT;
      psel   <= '0;
    end else if (cfg_wr) begin
      window <= bus_wdata[CNT_W-1:0];
      psel   <= bus_wdata[PSEL_LSB +: PSEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         flag <= 1'b0;
    else if (flag_set)               flag <= 1'b1;
    else if (stat_wr && !bus_wdata[0]) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_req) begin
      case (bus_addr)
        OFS_CTRL: rdata = DATA_W'({enable, count});
        OFS_CFG:  rdata = DATA_W'({psel, window});
        OFS_STAT: rdata = DATA_W'(flag);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic              enable, tripped, run, tick;
  logic              load, early, expire, hit_floor, flag, trip;
  logic [CNT_W-1:0]  count, window, load_val;
  logic [PSEL_W-1:0] psel;

  assign bus_ready = 1'b1;
  assign run       = enable && !tripped;
  assign trip      = (expire || early) && !tripped;

  wdt_regs u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .halted(tripped), .count(count), .flag_set(hit_floor),
    .enable(enable), .window(window), .psel(psel),
    .load(load), .load_val(load_val), .early(early),
    .flag(flag), .rdata(bus_rdata)
  );

  wdt_prescaler #(.BASE_DIV(BASE_DIV), .PSEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .restart(load),
    .psel(psel), .tick(tick)
  );

  wdt_downcount u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .load(load), .load_val(load_val),
    .count(count), .expire(expire), .hit_floor(hit_floor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      tripped <= tripped || trip;
      rst_req <= trip;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_ready,
  input logic             rst_req,
  input logic             enable,
  input logic             tripped,
  input logic             load,
  input logic             ctrl_hit,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] window
);
  assert_ready_R10: assert property (@(posedge clk) disable iff (rst) bus_ready);

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    enable |=> enable);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!enable && !load) |=> $stable(count));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && !tripped && !load) |=>
      (count == $past(count) || count == $past(count) - CNT_W'(1)));

  assert_early_refresh_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && enable && !tripped && count > window) |=> rst_req);

  assert_pulse_once_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_frozen_after_trip_R8: assert property (@(posedge clk) disable iff (rst)
    tripped |=> ($stable(count) && !rst_req));
endmodule

bind win_watchdog wdt_checker u_chk (
  .clk(clk), .rst(rst), .bus_ready(bus_ready), .rst_req(rst_req),
  .enable(enable), .tripped(tripped), .load(load),
  .ctrl_hit(bus_valid && bus_write && bus_addr == wdt_pkg::OFS_CTRL),
  .count(count), .window(window)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst, bus_valid, bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  wire         bus_ready;
  wire  [31:0] bus_rdata;
  wire         rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  win_watchdog #(.BASE_DIV(BASE)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input int limit, output int n);
    n = 1;
    while (!rst_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int period(input int ps);
    return BASE << ps;
  endfunction

  function automatic int exp_timeout(input int v, input int ps);
    int t;
    t = (v > 'h40) ? v - 'h3F : 1;
    return t * period(ps) + 1;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, pulses;
    void'($urandom(32'd2024));
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    @(negedge clk);
    do_reset();

    // R1 reset state, R10 map
    check("R1 rst_req", 32'(rst_req), 0);
    rd(4'h0, d); check("R1 ctrl", d, 32'h7F);
    rd(4'h4, d); check("R1 cfg", d, 32'h7F);
    rd(4'h8, d); check("R1 stat", d, 0);
    rd(4'hC, d); check("R10 unmapped", d, 0);
    check("R10 ready", 32'(bus_ready), 1);

    // R3 disabled counter holds, load while disabled
    repeat (40) @(negedge clk);
    rd(4'h0, d); check("R3 idle hold", d, 32'h7F);
    wr(4'h0, 32'h55);
    repeat (40) @(negedge clk);
    rd(4'h0, d); check("R3 load while off", d, 32'h55);
    check("R3 no request", 32'(rst_req), 0);

    // R10 configuration layout
    wr(4'h4, (32'd2 << 7) | 32'h66);
    rd(4'h4, d); check("R10 cfg readback", d, 32'h166);

    // R5 full-range expiry, R8 pulse and halt
    do_reset();
    wr(4'h0, 32'hFF);
    measure(5000, n); check("R5 expiry 0x7F", n, exp_timeout('h7F, 0));
    @(negedge clk); check("R8 pulse width", 32'(rst_req), 0);
    wr(4'h0, 32'hC0);
    wr(4'h8, 32'h0);
    rd(4'h0, d); check("R8 ctrl frozen", d, 32'hBF);
    rd(4'h8, d); check("R8 stat write ignored", d, 1);
    pulses = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
    check("R8 no further pulse", pulses, 0);

    // R5 loads at and below the floor
    do_reset();
    wr(4'h0, 32'hC0);
    measure(100, n); check("R5 load 0x40", n, exp_timeout('h40, 0));
    do_reset();
    wr(4'h0, 32'h90);
    measure(100, n); check("R5 load 0x10", n, exp_timeout('h10, 0));

    // R4 step timing with psel 1
    do_reset();
    wr(4'h4, (32'd1 << 7) | 32'h7F);
    wr(4'h0, 32'hF0);
    repeat (7) @(negedge clk);
    rd(4'h0, d); check("R4 before tick", d, 32'hF0);
    @(negedge clk);
    rd(4'h0, d); check("R4 after tick", d, 32'hEF);

    // R4/R5 random expiry timing
    for (int i = 0; i < 12; i++) begin
      int ps, v;
      ps = int'($urandom % 4);
      v  = 'h40 + int'($urandom % 64);
      do_reset();
      wr(4'h4, 32'(ps << 7) | 32'h7F);
      wr(4'h0, 32'h80 | 32'(v));
      measure(5000, n); check("R5 random expiry", n, exp_timeout(v, ps));
    end

    // R2 sticky enable
    do_reset();
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'h70);
    rd(4'h0, d); check("R2 enable kept", d, 32'hF0);
    check("R2 no request", 32'(rst_req), 0);

    // R6 boundary: count equal to window
    do_reset();
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'hFF);
    check("R6 equal window", 32'(rst_req), 0);

    // R7 directed early refresh
    do_reset();
    wr(4'h4, 32'h50);
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'hFF);
    check("R7 early request", 32'(rst_req), 1);
    @(negedge clk); check("R8 early pulse width", 32'(rst_req), 0);

    // R6/R7 random refresh timing
    for (int i = 0; i < 16; i++) begin
      int ps, w, v, nv, m, cur;
      ps = int'($urandom % 4);
      w  = 'h40 + int'($urandom % 64);
      v  = 'h41 + int'($urandom % 63);
      nv = 'h40 + int'($urandom % 64);
      m  = int'($urandom % 32'((v - 'h40) * period(ps)));
      do_reset();
      wr(4'h4, 32'(ps << 7) | 32'(w));
      wr(4'h0, 32'h80 | 32'(v));
      repeat (m) @(negedge clk);
      cur = v - m / period(ps);
      wr(4'h0, 32'h80 | 32'(nv));
      if (cur > w) begin
        check("R7 random early", 32'(rst_req), 1);
      end else begin
        check("R6 random in window", 32'(rst_req), 0);
        rd(4'h0, d); check("R6 reload value", d, 32'h80 | 32'(nv));
      end
    end

    // R9 status flag
    do_reset();
    wr(4'h0, 32'hC2);
    rd(4'h8, d); check("R9 flag clear", d, 0);
    repeat (8) @(negedge clk);
    rd(4'h8, d); check("R9 flag set at 0x40", d, 1);
    wr(4'h8, 32'h1);
    rd(4'h8, d); check("R9 write one keeps", d, 1);
    wr(4'h8, 32'h0);
    rd(4'h8, d); check("R9 write zero clears", d, 0);
    check("R5 not yet", 32'(rst_req), 0);
    repeat (2) @(negedge clk);
    check("R5 rollover request", 32'(rst_req), 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule